// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single read or write requests into bus cycles on a processor-side bus. The bus has a 20-bit address and 16-bit data. The low 16 address bits and the data share one set of lines. The top four address bits share their lines with status. Each cycle runs through the phases T1, T2, T3 and T4, one clock per phase. Zero or more wait phases (Tw) can follow T2 while the slave holds READY low.

In T1 the block raises the address strobe and puts the address on the shared lines. It also drives the byte-select pair, which is the active-low high-byte enable together with address bit 0. From T2 on, the shared lines carry write data or are released for read data. The upper lines carry status, and the high-byte enable line carries a constant 1. The read and write strobes, the data enable, the data direction and the memory/IO select frame each cycle.

A word access at an odd address cannot be done in one cycle, so the block splits it into two byte cycles. The requester sees a single request with one completion pulse. A request can be taken while the block is idle, or in the completion cycle so that the next cycle follows without a gap.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While rst_ni is low, and after its release until a request arrives, the block drives ale_o=0, rd_n_o=1, wr_n_o=1, den_n_o=1, bhe_n_o=1, ad_oe_o=0 and done_o=0.
- R2: In T1, which is the first cycle after a request is accepted, ale_o is high for exactly one cycle, ad_oe_o=1, ad_o carries address bits 15..0 and as_o carries address bits 19..16.
- R3: From T2 to the end of the cycle, as_o carries the status value 4'b0010 and bhe_n_o is held at 1.
- R4: During T1 the pair {bhe_n_o, ad_o[0]} is 2'b00 for a word at an even address, 2'b01 for a byte at an odd address and 2'b10 for a byte at an even address.
- R5: READY is sampled at the end of T2 and at the end of each Tw. Each low sample adds one Tw. For a single-piece cycle with w wait phases, done_o is high in the (4+w)-th cycle after the accepting edge.
- R6: rd_n_o (for a read) or wr_n_o (for a write) is low in T2, in every Tw and in T3, which is 2+w cycles. The two strobes are never low together, and den_n_o is low whenever either one is. dt_r_o is 1 for a write and 0 for a read. m_io_o is 1 for memory and 0 when req_io_i was 1.
- R7: Read data is taken from ad_i at the end of T3 and shown on rdata_o from T4. A word gives ad_i[15:8]:ad_i[7:0]. A byte gives the addressed lane, upper lane for odd and lower lane for even, zero-extended.
- R8: For a write, ad_o carries the data with ad_oe_o=1 from T2 through T4. A word at an even address puts bits 15..0 as given. A byte appears on both lanes. During a read strobe ad_oe_o is 0.
- R9: A word at an odd address A runs as two cycles. The first is an upper-lane byte cycle at A that carries data bits 7..0. The second is a lower-lane byte cycle at A+1 (modulo 2^20) that carries bits 15..8. done_o rises once, in the (8+w1+w2)-th cycle.
- R10: done_o is a one-cycle pulse in T4 of the last piece of a request.
- R11: req_start_i is accepted only when the block is idle or done_o is high. A start in the done cycle gives T1 in the very next cycle. A start at any other time is ignored and causes no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Request strobe |
| req_addr_i | input | 20 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata_i | input | 16 | Write data; a byte uses bits 7..0 |
| ready_i | input | 1 | Slave ready, low adds wait phases |
| ad_i | input | 16 | Shared lines as seen from the bus (read data) |
| ad_o | output | 16 | Shared lines, driven value |
| ad_oe_o | output | 1 | Drive enable of the shared lines |
| as_o | output | 4 | Address bits 19..16 in T1, status afterwards |
| ale_o | output | 1 | Address strobe, high in T1 |
| bhe_n_o | output | 1 | High-byte enable (low active) in T1, 1 afterwards |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| m_io_o | output | 1 | 1 = memory, 0 = I/O |
| den_n_o | output | 1 | Data transceiver enable, active low |
| dt_r_o | output | 1 | 1 = transmit (write), 0 = receive (read) |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | Completion pulse |

## Verification
Counting from the accepting edge, done_o is due (4+w) cycles later, or (8+w1+w2) cycles for a split word. The bench counts falling edges from the edge where it raised the start and compares that count with this formula. A bench-side slave samples the T1 address and byte-select pair, and the status and bhe_n_o in the first strobe cycle, at the falling edge inside each phase. It holds READY low for a programmed number of strobe cycles. It serves read data for the whole strobe window, so data is present at the end of T3. rdata_o and the slave memory are compared in the done cycle with values worked out from a shadow byte array.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  // encoded as {bhe_n, a0}
  typedef enum logic [1:0] {
    LN_WORD = 2'b00,
    LN_HI   = 2'b01,
    LN_LO   = 2'b10,
    LN_NONE = 2'b11
  } lane_e;
endpackage

// File: rtl/mbus_lane_sel.sv
module mbus_lane_sel
  import mbus_pkg::*;
(
  input  logic  word_i,
  input  logic  odd_i,
  input  logic  piece_i,
  output lane_e lane_o,
  output logic  split_o
);
  always_comb begin
    split_o = word_i & odd_i;
    if (word_i && !odd_i)  lane_o = LN_WORD;
    else if (split_o)      lane_o = piece_i ? LN_LO : LN_HI;
    else if (odd_i)        lane_o = LN_HI;
    else                   lane_o = LN_LO;
  end
endmodule

// File: rtl/mbus_tstate_fsm.sv
module mbus_tstate_fsm
  import mbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    split_i,
  input  logic    ready_i,
  output tstate_e state_o,
  output logic    piece_o,
  output logic    last_o,
  output logic    accept_o
);
  tstate_e state_q, state_d;
  logic    piece_q, piece_d;

  always_comb begin
    state_d  = state_q;
    piece_d  = piece_q;
    last_o   = !split_i || piece_q;
    accept_o = start_i && (state_q == TS_IDLE || (state_q == TS_T4 && last_o));
    unique case (state_q)
      TS_IDLE:      if (start_i) state_d = TS_T1;
      TS_T1:        state_d = TS_T2;
      TS_T2, TS_TW: state_d = ready_i ? TS_T3 : TS_TW;
      TS_T3:        state_d = TS_T4;
      TS_T4: begin
        if (!last_o) begin
          state_d = TS_T1;
          piece_d = 1'b1;
        end else if (start_i) begin
          state_d = TS_T1;
        end else begin
          state_d = TS_IDLE;
        end
      end
      default:      state_d = TS_IDLE;
    endcase
    if (accept_o) piece_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      piece_q <= 1'b0;
    end else begin
      state_q <= state_d;
      piece_q <= piece_d;
    end
  end

  assign state_o = state_q;
  assign piece_o = piece_q;
endmodule

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              word_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              piece_i,
  input  logic              split_i,
  input  lane_e             lane_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] lane_data_o,
  output logic              odd_o,
  output logic              word_o,
  output logic              write_o,
  output logic              io_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, word_q, io_q;
  logic [BYTE_W-1:0] byte_val, lo_lane, hi_lane;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      io_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      write_q <= write_i;
      word_q  <= word_i;
      io_q    <= io_i;
    end
  end

  assign lo_lane = ad_i[BYTE_W-1:0];
  assign hi_lane = ad_i[DATA_W-1:BYTE_W];

  // a split word assembles across its two pieces
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      unique case (lane_i)
        LN_WORD: rdata_q <= ad_i;
        LN_HI: begin
          if (split_i) rdata_q[BYTE_W-1:0] <= hi_lane;
          else         rdata_q <= {{BYTE_W{1'b0}}, hi_lane};
        end
        LN_LO: begin
          if (split_i) rdata_q[DATA_W-1:BYTE_W] <= lo_lane;
          else         rdata_q <= {{BYTE_W{1'b0}}, lo_lane};
        end
        default: rdata_q <= rdata_q;
      endcase
    end
  end

  always_comb begin
    byte_val    = (split_i && piece_i) ? wdata_q[DATA_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
    lane_data_o = (lane_i == LN_WORD) ? wdata_q : {byte_val, byte_val};
  end

  assign paddr_o = addr_q + ADDR_W'(piece_i);
  assign odd_o   = addr_q[0];
  assign word_o  = word_q;
  assign write_o = write_q;
  assign io_o    = io_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int STATUS_VAL = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_start_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic                     req_write_i,
  input  logic                     req_word_i,
  input  logic                     req_io_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     ready_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] as_o,
  output logic                     ale_o,
  output logic                     bhe_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     m_io_o,
  output logic                     den_n_o,
  output logic                     dt_r_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [HI_W-1:0] STATUS_BITS = HI_W'(STATUS_VAL);

  tstate_e           state_w;
  logic              piece_w, last_w, accept_w, split_w;
  logic              odd_w, word_w, write_w, io_w;
  lane_e             lane_w;
  logic [ADDR_W-1:0] paddr_w;
  logic [DATA_W-1:0] lane_data_w;
  logic              strobe_ph, data_ph, active;

  mbus_tstate_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (req_start_i),
    .split_i  (split_w),
    .ready_i  (ready_i),
    .state_o  (state_w),
    .piece_o  (piece_w),
    .last_o   (last_w),
    .accept_o (accept_w)
  );

  mbus_lane_sel u_lane (
    .word_i  (word_w),
    .odd_i   (odd_w),
    .piece_i (piece_w),
    .lane_o  (lane_w),
    .split_o (split_w)
  );

  mbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept_w),
    .addr_i      (req_addr_i),
    .write_i     (req_write_i),
    .word_i      (req_word_i),
    .io_i        (req_io_i),
    .wdata_i     (req_wdata_i),
    .piece_i     (piece_w),
    .split_i     (split_w),
    .lane_i      (lane_w),
    .capture_i   (state_w == TS_T3),
    .ad_i        (ad_i),
    .paddr_o     (paddr_w),
    .lane_data_o (lane_data_w),
    .odd_o       (odd_w),
    .word_o      (word_w),
    .write_o     (write_w),
    .io_o        (io_w),
    .rdata_o     (rdata_o)
  );

  // pin decode
  always_comb begin
    active    = (state_w != TS_IDLE);
    strobe_ph = (state_w == TS_T2) || (state_w == TS_TW) || (state_w == TS_T3);
    data_ph   = strobe_ph || (state_w == TS_T4);
    ale_o     = (state_w == TS_T1);
    ad_o      = ale_o ? paddr_w[DATA_W-1:0] : lane_data_w;
    ad_oe_o   = ale_o || (data_ph && write_w);
    as_o      = ale_o ? paddr_w[ADDR_W-1:DATA_W] : (active ? STATUS_BITS : '0);
    bhe_n_o   = ale_o ? lane_w[1] : 1'b1;
    rd_n_o    = !(strobe_ph && !write_w);
    wr_n_o    = !(strobe_ph && write_w);
    den_n_o   = !strobe_ph;
    m_io_o    = !io_w;
    dt_r_o    = write_w;
    done_o    = (state_w == TS_T4) && last_w;
  end
endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk
  import mbus_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       ale_o,
  input logic       bhe_n_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       den_n_o,
  input logic       dt_r_o,
  input logic       ad_oe_o,
  input logic       done_o,
  input logic [2:0] state_i
);
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  p_den_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !den_n_o);
  p_dir_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> dt_r_o);
  p_dir_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !dt_r_o);
  p_ale_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  p_s7_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> bhe_n_o);
  p_wait_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == TS_T2 && !ready_i) |=> (state_i == TS_TW));
  p_wait_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == TS_TW && ready_i) |=> (state_i == TS_T3));
  p_rd_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .ale_o   (ale_o),
  .bhe_n_o (bhe_n_o),
  .rd_n_o  (rd_n_o),
  .wr_n_o  (wr_n_o),
  .den_n_o (den_n_o),
  .dt_r_o  (dt_r_o),
  .ad_oe_o (ad_oe_o),
  .done_o  (done_o),
  .state_i (state_w)
);

// File: tb/sim_mbus_cycle_seq.sv
module sim_mbus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] addr = '0;
  logic        wr = 1'b0, wd = 1'b0, io = 1'b0;
  logic [15:0] wdata = '0;
  logic        ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_o, rdata;
  logic [3:0]  as_o;
  logic        ad_oe, ale, bhe_n, rd_n, wr_n, m_io, den_n, dt_r, done;

  int checks = 0;
  int errors = 0;
  int wcfg = 0;

  always #10 clk = ~clk;

  mbus_cycle_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_addr_i(addr),
    .req_write_i(wr), .req_word_i(wd), .req_io_i(io), .req_wdata_i(wdata),
    .ready_i(ready), .ad_i(ad_in), .ad_o(ad_o), .ad_oe_o(ad_oe), .as_o(as_o),
    .ale_o(ale), .bhe_n_o(bhe_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .m_io_o(m_io),
    .den_n_o(den_n), .dt_r_o(dt_r), .rdata_o(rdata), .done_o(done)
  );

  // bench-side slave: 64-byte memory, records each piece
  logic [7:0]  mem [64];
  logic [19:0] rec_addr [4];
  logic [1:0]  rec_pair [4];
  logic [3:0]  rec_stat [4];
  logic        rec_s7 [4], rec_mio [4], rec_dtr [4], rec_rd [4], rec_bad [4];
  int          rec_strb [4];
  int          pcnt = 0;
  int          wleft = 0;
  int          cur = 0;
  bit          first = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = 8'((i * 7 + 3) & 255);
      ready = 1'b1;
    end else if (ale) begin
      cur = pcnt % 4;
      rec_addr[cur] = {as_o, ad_o};
      rec_pair[cur] = {bhe_n, ad_o[0]};
      rec_mio[cur]  = m_io;
      rec_dtr[cur]  = dt_r;
      rec_strb[cur] = 0;
      rec_bad[cur]  = 1'b0;
      rec_rd[cur]   = 1'b0;
      rec_stat[cur] = 4'hF;
      rec_s7[cur]   = 1'b0;
      first = 1'b1;
      wleft = wcfg;
      pcnt++;
      ready = 1'b1;
    end else if (!rd_n || !wr_n) begin
      logic [5:0] b;
      b = {rec_addr[cur][5:1], 1'b0};
      if (first) begin
        rec_stat[cur] = as_o;
        rec_s7[cur]   = bhe_n;
        first = 1'b0;
      end
      rec_strb[cur]++;
      rec_rd[cur] = !rd_n;
      ready = (wleft == 0);
      if (wleft > 0) wleft--;
      if (!rd_n) begin
        ad_in = {mem[b | 6'd1], mem[b]};
        if (ad_oe) rec_bad[cur] = 1'b1;
      end else begin
        if (!ad_oe) rec_bad[cur] = 1'b1;
        if (rec_pair[cur] != 2'b00 && ad_o[15:8] != ad_o[7:0]) rec_bad[cur] = 1'b1;
        if (!rec_pair[cur][0]) mem[b] = ad_o[7:0];
        if (!rec_pair[cur][1]) mem[b | 6'd1] = ad_o[15:8];
      end
    end else begin
      ready = 1'b1;
    end
  end

  logic [7:0] em [64];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_piece(input int k, input logic [19:0] a, input logic [1:0] pair,
                             input bit w_r, input bit io_r, input int w);
    chk(rec_addr[k] == a, "R2 T1 address", 32'(rec_addr[k]), 32'(a));
    chk(rec_pair[k] == pair, "R4 byte select pair", 32'(rec_pair[k]), 32'(pair));
    chk(rec_stat[k] == 4'b0010 && rec_s7[k], "R3 status and S7",
        32'({rec_s7[k], rec_stat[k]}), 32'h12);
    chk(rec_mio[k] == !io_r && rec_dtr[k] == w_r && rec_rd[k] == !w_r, "R6 m_io/dt_r/strobe kind",
        32'({rec_mio[k], rec_dtr[k], rec_rd[k]}), 32'({!io_r, w_r, !w_r}));
    chk(rec_strb[k] == 2 + w, "R6 strobe width", 32'(rec_strb[k]), 32'(2 + w));
    chk(!rec_bad[k], "R8 lane drive and release", 32'(rec_bad[k]), 32'h0);
  endtask

  // drives a request at the current falling edge; returns in the done cycle
  task automatic xfer(input logic [19:0] a, input bit w_r, input bit wd_r, input bit io_r,
                      input logic [15:0] d, input int w);
    int n, p0, lat;
    bit sp;
    logic [5:0] i0, i1;
    logic [15:0] exp;
    wcfg = w;
    p0 = pcnt;
    addr = a; wr = w_r; wd = wd_r; io = io_r; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    sp  = wd_r && a[0];
    lat = sp ? 8 + 2 * w : 4 + w;
    chk(n == lat, sp ? "R9 split latency" : "R5 done latency", 32'(n), 32'(lat));
    chk(pcnt - p0 == (sp ? 2 : 1), "R9 piece count", 32'(pcnt - p0), sp ? 32'd2 : 32'd1);
    if (sp) begin
      check_piece(p0 % 4, a, 2'b01, w_r, io_r, w);
      check_piece((p0 + 1) % 4, a + 20'd1, 2'b10, w_r, io_r, w);
    end else begin
      check_piece(p0 % 4, a, wd_r ? 2'b00 : (a[0] ? 2'b01 : 2'b10), w_r, io_r, w);
    end
    i0 = a[5:0];
    i1 = a[5:0] + 6'd1;
    if (w_r) begin
      em[i0] = d[7:0];
      if (wd_r) em[i1] = d[15:8];
      chk(mem[i0] == em[i0], "R8 written low byte", 32'(mem[i0]), 32'(em[i0]));
      chk(mem[i1] == em[i1], "R8 neighbour byte", 32'(mem[i1]), 32'(em[i1]));
    end else begin
      exp = wd_r ? {em[i1], em[i0]} : {8'h00, em[i0]};
      chk(rdata == exp, sp ? "R9 split read data" : "R7 read data", 32'(rdata), 32'(exp));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) em[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && den_n && bhe_n && !ad_oe && !done, "R1 in reset",
        32'({ale, rd_n, wr_n, den_n, bhe_n, ad_oe, done}), 32'b0111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ale && rd_n && wr_n && den_n && bhe_n && !ad_oe && !done, "R1 after release",
        32'({ale, rd_n, wr_n, den_n, bhe_n, ad_oe, done}), 32'b0111100);

    // sweep: parity, direction, size, waits, space
    for (int i = 0; i < 72; i++) begin
      logic [19:0] a;
      a = {4'(i), 10'h2A5, 6'(i * 5)};
      if (i % 3 == 0) @(negedge clk);
      xfer(a, ((i / 6) % 2) == 1, ((i / 12) % 2) == 1, (i % 5) == 0,
           16'(i * 16'h1357 + 16'h0BAD), (i / 24) % 3);
    end

    // R9 wrap at the top of the address space, write then read back
    xfer(20'hFFFFF, 1'b1, 1'b1, 1'b0, 16'hC3A5, 1);
    xfer(20'hFFFFF, 1'b0, 1'b1, 1'b0, 16'h0000, 2);
    xfer(20'h12341, 1'b0, 1'b1, 1'b1, 16'h0000, 0);

    // R11 start during a running cycle is ignored; R10 single pulse
    begin
      int p0;
      @(negedge clk);
      wcfg = 2;
      p0 = pcnt;
      addr = 20'h00010; wr = 1'b1; wd = 1'b1; io = 1'b0; wdata = 16'hBEEF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      addr = 20'h00020; wdata = 16'h5A5A; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      em[16] = 8'hEF; em[17] = 8'hBE;
      @(negedge clk);
      chk(!done, "R10 done one cycle", 32'(done), 32'h0);
      repeat (3) @(negedge clk);
      chk(pcnt - p0 == 1, "R11 ignored start makes no cycle", 32'(pcnt - p0), 32'h1);
      chk(mem[32] == em[32] && mem[33] == em[33], "R11 ignored start writes nothing",
          32'({mem[33], mem[32]}), 32'({em[33], em[32]}));
      chk({mem[17], mem[16]} == 16'hBEEF, "R11 accepted write", 32'({mem[17], mem[16]}), 32'hBEEF);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule